// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block drives the two-wire management bus used to configure and monitor an Ethernet PHY. Software programs a clock divider, a PHY address, a register number and, for writes, a 16-bit data word through a small word-indexed register port. It then sets one bit of a command register to launch a single write, a single read, or a repeating status scan. The block generates the management clock, shifts out each frame most significant bit first, releases the data line for the turnaround and data bits of a read, and collects the 16 returned bits.

The data line is presented as a separate output value, output enable and input, so the pad's tri-state buffer stays outside the block. Scan mode re-reads the addressed register back to back and keeps a link-failure flag current from each returned word. A separate flag tells software that no scan word has arrived yet.

Top module: `mdio_master`

## Requirements
- R1: The mode register (index 0) holds the divider in bits 7:0 and the no-preamble flag in bit 8. Bit 0 of the divider always reads and acts as 0. Its reset value is 0x64. The management clock period is the divider value in system clocks, with a divider below 2 acting as 2, and both halves of the period are equal.
- R2: Command register (index 1): bit 2 launches a write, bit 1 launches a read and bit 0 launches a scan. When several bits are set, write beats read and read beats scan.
- R3: The address register (index 2) holds the PHY address in bits 4:0 and the register number in bits 12:8. Each frame goes out MSB first as 32 preamble ones, start 01, opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register number, 2 turnaround bits and 16 data bits, for 64 clock periods.
- R4: A write frame drives the turnaround as 1 then 0, then transmit data register (index 3) bits 15:0. The data line changes only while the management clock is low.
- R5: During the 2 turnaround and 16 data bits of a read, the output enable is low. The block samples the input on each rising management clock edge and places the 16 bits, first received as bit 15, in the receive register (index 4) when the frame ends.
- R6: With the no-preamble flag set, the preamble is omitted and a frame lasts 32 clock periods.
- R7: The status register (index 5) bit 1 is high while a frame is in progress. Status reads 0 after reset. When idle, the management clock is low and the output enable is low.
- R8: A command is accepted only after the command register has been seen at zero since the last accepted command. A command left set after busy drops starts nothing.
- R9: While command bit 0 stays set, scan frames (reads) run back to back. Each completed scan frame sets status bit 0 (link failure) to the inverse of bit 2 of the returned word. Clearing bit 0 lets the current frame finish and then stops.
- R10: Status bit 2 (scan data invalid) is set when a scan starts from idle and cleared when the first scan frame completes.
- R11: The receive and status registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble, a 3-bit register index and a reset divider of 100. Because the divider is a runtime register, those defaults still let the bench reach divide ratios of 2, 4 and 10, including the odd value that must round down. The preamble-free 32-bit frame, back-to-back scan frames and the stop at a frame boundary all fit within a few thousand cycles. A PHY model in the bench decodes every clock period and compares the driven bits and the half-period lengths against frames it builds from the programmed fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned PHY_AW   = 5;
  localparam int unsigned RNUM_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned BODY_W   = 2 + 2 + PHY_AW + RNUM_W + 2 + DATA_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_SCAN  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  // half period of the management clock in system clocks
  function automatic logic [DIV_W-1:0] half_of(input logic [DIV_W-1:0] div);
    if (div < DIV_W'(2)) return DIV_W'(1);
    return div >> 1;
  endfunction

  // frame without preamble, MSB goes out first
  function automatic logic [BODY_W-1:0] frame_body(input logic wr,
                                                   input logic [PHY_AW-1:0] phy,
                                                   input logic [RNUM_W-1:0] rnum,
                                                   input logic [DATA_W-1:0] wd);
    return {2'b01, (wr ? 2'b01 : 2'b10), phy, rnum, (wr ? 2'b10 : 2'b11),
            (wr ? wd : {DATA_W{1'b1}})};
  endfunction

  function automatic op_e pick_op(input logic [2:0] cmd);
    if (cmd[2]) return OP_WRITE;
    if (cmd[1]) return OP_READ;
    if (cmd[0]) return OP_SCAN;
    return OP_IDLE;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] half,
  output logic          mdc,
  output logic          rise_tick,
  output logic          fall_tick
);
  logic [DW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt >= half - 1'b1);
  assign rise_tick = wrap & ~mdc;
  assign fall_tick = wrap & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic              nopre,
  input  logic [PHY_AW-1:0] phy,
  input  logic [RNUM_W-1:0] rnum,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              rel_phase,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned FRAME_W = PRE_BITS + BODY_W;
  localparam int unsigned CW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CW-1:0]      left;
  logic               is_wr;
  logic [BODY_W-1:0]  body;

  assign body      = frame_body(start_wr, phy, rnum, wdata);
  assign done      = busy && fall_tick && (left == CW'(1));
  assign rel_phase = busy && !is_wr && (left <= CW'(DATA_W + 2));
  assign mdio_o    = shreg[FRAME_W-1];
  assign mdio_oe   = busy && !rel_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      is_wr <= 1'b0;
      left  <= '0;
      shreg <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      is_wr <= start_wr;
      left  <= nopre ? CW'(BODY_W) : CW'(FRAME_W);
      shreg <= nopre ? {body, {PRE_BITS{1'b0}}} : {{PRE_BITS{1'b1}}, body};
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy && fall_tick) begin
      shreg <= shreg << 1;
      left  <= left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (busy && !is_wr && rise_tick && (left <= CW'(DATA_W)))
      rdata <= {rdata[DATA_W-2:0], mdio_i};
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int unsigned      RA_W    = 3,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic [DATA_W-1:0] seq_rdata,
  output logic              start,
  output logic              start_wr,
  output logic              nopre,
  output logic [DIV_W-1:0]  half,
  output logic [PHY_AW-1:0] phy,
  output logic [RNUM_W-1:0] rnum,
  output logic [DATA_W-1:0] wdata,
  output logic              scan_idle_start,
  output logic              armed,
  output logic              cur_scan,
  output logic              invalid,
  output logic [2:0]        cmd_q
);
  localparam logic [RA_W-1:0] A_MODE = RA_W'(0);
  localparam logic [RA_W-1:0] A_CMD  = RA_W'(1);
  localparam logic [RA_W-1:0] A_ADDR = RA_W'(2);
  localparam logic [RA_W-1:0] A_TX   = RA_W'(3);
  localparam logic [RA_W-1:0] A_RX   = RA_W'(4);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(5);

  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rx_q;
  logic              cur_wr;
  logic              link_fail;
  logic              go_idle;
  logic              go_next;
  op_e               sel;
  logic              unused_wd;

  assign unused_wd = ^reg_wdata[31:16];
  assign half      = half_of(div_q);
  assign sel       = pick_op(cmd_q);
  assign go_idle   = !seq_busy && armed && (sel != OP_IDLE);
  assign go_next   = seq_done && cur_scan && cmd_q[0];
  assign start     = go_idle || go_next;
  assign start_wr  = go_idle && (sel == OP_WRITE);
  assign scan_idle_start = go_idle && (sel == OP_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_RST;
      nopre <= 1'b0;
      cmd_q <= '0;
      phy   <= '0;
      rnum  <= '0;
      wdata <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_MODE: begin
          div_q <= {reg_wdata[DIV_W-1:1], 1'b0};
          nopre <= reg_wdata[DIV_W];
        end
        A_CMD:  cmd_q <= reg_wdata[2:0];
        A_ADDR: begin
          phy  <= reg_wdata[PHY_AW-1:0];
          rnum <= reg_wdata[8 +: RNUM_W];
        end
        A_TX:   wdata <= reg_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      cur_scan  <= 1'b0;
      cur_wr    <= 1'b0;
      rx_q      <= '0;
      link_fail <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      if (cmd_q == 3'b000) armed <= 1'b1;
      else if (go_idle)    armed <= 1'b0;
      if (start) begin
        cur_scan <= go_idle ? (sel == OP_SCAN) : 1'b1;
        cur_wr   <= start_wr;
      end
      if (seq_done && !cur_wr) rx_q <= seq_rdata;
      if (scan_idle_start) invalid <= 1'b1;
      if (seq_done && cur_scan) begin
        invalid   <= 1'b0;
        link_fail <= ~seq_rdata[2];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: reg_rdata = 32'({nopre, div_q});
      A_CMD:  reg_rdata = 32'(cmd_q);
      A_ADDR: reg_rdata = 32'({rnum, 3'b000, phy});
      A_TX:   reg_rdata = 32'(wdata);
      A_RX:   reg_rdata = 32'(rx_q);
      A_STAT: reg_rdata = 32'({invalid, seq_busy, link_fail});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned      PRE_BITS = 32,
  parameter int unsigned      RA_W     = 3,
  parameter logic [DIV_W-1:0] DIV_RST  = 8'd100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mdc,
  output logic            mdio_o,
  output logic            mdio_oe,
  input  logic            mdio_i
);
  logic              busy, done, rel_phase;
  logic              start, start_wr, nopre;
  logic [DIV_W-1:0]  half;
  logic [PHY_AW-1:0] phy;
  logic [RNUM_W-1:0] rnum;
  logic [DATA_W-1:0] wdata, rdata;
  logic              rise_tick, fall_tick;
  logic              scan_idle_start, armed, cur_scan, invalid;
  logic [2:0]        cmd_q;

  mdio_regs #(.RA_W(RA_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_busy(busy), .seq_done(done), .seq_rdata(rdata),
    .start(start), .start_wr(start_wr), .nopre(nopre), .half(half),
    .phy(phy), .rnum(rnum), .wdata(wdata),
    .scan_idle_start(scan_idle_start), .armed(armed), .cur_scan(cur_scan),
    .invalid(invalid), .cmd_q(cmd_q)
  );

  mdio_clkgen #(.DW(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .nopre(nopre), .phy(phy), .rnum(rnum), .wdata(wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rel_phase(rel_phase),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       done,
  input logic       scan_idle_start,
  input logic       armed,
  input logic       cur_scan,
  input logic       invalid,
  input logic [2:0] cmd_q
);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_change_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o));

  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !armed) |=> !busy);

  assert_scan_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_scan && cmd_q[0]) |=> busy);

  assert_invalid_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_idle_start |=> (invalid && busy));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .done(done), .scan_idle_start(scan_idle_start),
  .armed(armed), .cur_scan(cur_scan), .invalid(invalid), .cmd_q(cmd_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;

  int n_chk = 0, n_fail = 0, cyc = 0;
  // PHY / reference model state
  int          pos = 0, frame_n = 64, exp_gap = 4, gap_cnt = 0, rises = 0;
  bit          exp_wr = 1'b0, frame_err = 1'b0, gap_err = 1'b0, mdc_prev = 1'b0;
  logic [31:0] exp_body = 32'd0;
  logic [15:0] phy_val = 16'd0;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [31:0] body_of(bit w, int phy, int rg, int d);
    logic [31:0] b;
    b = 32'h4000_0000;
    b = b | ((w ? 32'd1 : 32'd2) << 28);
    b = b | (32'(phy & 31) << 23) | (32'(rg & 31) << 18);
    b = b | ((w ? 32'd2 : 32'd3) << 16);
    b = b | (w ? 32'(d & 16'hFFFF) : 32'h0000_FFFF);
    return b;
  endfunction

  function automatic bit exp_bit(int i);
    if (frame_n == 64 && i < 32) return 1'b1;
    return exp_body[31 - (i - (frame_n - 32))];
  endfunction

  // behavioural PHY: evaluated every clock, away from the active edge
  always @(negedge clk) begin
    gap_cnt = gap_cnt + 1;
    if (mdc && !mdc_prev) begin
      int i;
      i = pos % frame_n;
      if (exp_wr || i < frame_n - 18) begin
        if (!mdio_oe || mdio_o !== exp_bit(i)) frame_err = 1'b1;
      end else if (mdio_oe) frame_err = 1'b1;
      if (pos > 0 && gap_cnt != exp_gap) gap_err = 1'b1;
      gap_cnt = 0;
      pos = pos + 1;
      rises = rises + 1;
    end
    if (!mdc && mdc_prev) begin
      int nx;
      nx = pos % frame_n;
      if (nx >= frame_n - 16) phy_drv = phy_val[15 - (nx - (frame_n - 16))];
      else phy_drv = 1'b1;
    end
    mdc_prev = mdc;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a[2:0];
    #1 d = reg_rdata;
  endtask

  task automatic wait_stat(input int bitn, input bit val, input string tag);
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd(5, s);
      if (s[bitn] == val) return;
    end
    chk(1'b0, tag, s, 32'(val) << bitn);
  endtask

  task automatic arm_model(bit w, int half, bit np, int phy, int rg, int d);
    exp_wr = w; exp_gap = 2 * half; frame_n = np ? 32 : 64;
    exp_body = body_of(w, phy, rg, d);
    pos = 0; frame_err = 1'b0; gap_err = 1'b0;
  endtask

  task automatic run_cmd(int cmd);
    wr(1, 32'(cmd));
    wait_stat(1, 1'b1, "busy rise");
    wait_stat(1, 1'b0, "busy fall");
  endtask

  initial begin
    logic [31:0] v;
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(5, v); chk(v == 32'd0, "R7 status after reset", v, 0);
    rd(0, v); chk(v == 32'h64, "R1 mode reset", v, 32'h64);
    chk(!mdc && !mdio_oe, "R7 idle lines", {mdc, mdio_oe}, 0);
    // odd divider rounds down
    wr(0, 32'h07); rd(0, v); chk(v == 32'h06, "R1 even divider", v, 32'h06);
    // write frame, divider 4
    wr(0, 32'h04);
    wr(2, 32'h0A13); rd(2, v); chk(v == 32'h0A13, "R3 address fields", v, 32'h0A13);
    wr(3, 32'hBEEF);
    arm_model(1'b1, 2, 1'b0, 5'h13, 5'h0A, 16'hBEEF);
    run_cmd(4);
    chk(!frame_err, "R4 write frame bits", 32'(frame_err), 0);
    chk(!gap_err, "R1 period div4", 32'(gap_err), 0);
    chk(pos == 64, "R3 frame length", pos, 64);
    wr(1, 0);
    // read frame
    phy_val = 16'hA5C3;
    arm_model(1'b0, 2, 1'b0, 5'h13, 5'h0A, 0);
    run_cmd(2);
    chk(!frame_err, "R5 read frame / release", 32'(frame_err), 0);
    rd(4, v); chk(v == 32'hA5C3, "R5 read data", v, 32'hA5C3);
    // command left set: no restart
    r0 = rises;
    repeat (100) @(negedge clk);
    rd(5, v); chk(v[1] == 1'b0 && rises == r0, "R8 no restart while set", rises - r0, 0);
    wr(1, 0);
    phy_val = 16'h1234;
    arm_model(1'b0, 2, 1'b0, 5'h13, 5'h0A, 0);
    run_cmd(2);
    rd(4, v); chk(v == 32'h1234, "R8 accepted after clear", v, 32'h1234);
    wr(1, 0);
    // no preamble, divider 2
    wr(0, 32'h102);
    wr(3, 32'h5A5A);
    arm_model(1'b1, 1, 1'b1, 5'h13, 5'h0A, 16'h5A5A);
    run_cmd(4);
    chk(!frame_err && pos == 32, "R6 short write frame", pos, 32);
    chk(!gap_err, "R1 period div2", 32'(gap_err), 0);
    wr(1, 0);
    phy_val = 16'h0F0F;
    arm_model(1'b0, 1, 1'b1, 5'h13, 5'h0A, 0);
    run_cmd(2);
    rd(4, v); chk(v == 32'h0F0F && !frame_err, "R6 short read", v, 32'h0F0F);
    wr(1, 0);
    // priority, divider 10
    wr(0, 32'h0A);
    arm_model(1'b1, 5, 1'b0, 5'h13, 5'h0A, 16'h5A5A);
    run_cmd(6);
    chk(!frame_err, "R2 write beats read", 32'(frame_err), 0);
    chk(!gap_err, "R1 period div10", 32'(gap_err), 0);
    wr(1, 0);
    phy_val = 16'h00FF;
    arm_model(1'b0, 5, 1'b0, 5'h13, 5'h0A, 0);
    run_cmd(3);
    rd(5, v); chk(v[2] == 1'b0 && !frame_err, "R2 read beats scan", v, 0);
    wr(1, 0);
    // scan
    wr(0, 32'h04);
    phy_val = 16'h0000;
    arm_model(1'b0, 2, 1'b0, 5'h13, 5'h0A, 0);
    wr(1, 1);
    wait_stat(1, 1'b1, "R9 scan busy");
    rd(5, v); chk(v[2] == 1'b1, "R10 invalid at scan start", v, 32'h6);
    wait_stat(2, 1'b0, "R10 invalid clears");
    rd(5, v); chk(v[0] == 1'b1, "R9 link fail from bit2=0", v, 32'h3);
    phy_val = 16'h0004;
    wait_stat(0, 1'b0, "R9 link restored");
    r0 = rises;
    wr(1, 0);
    wait_stat(1, 1'b0, "R9 scan stop");
    rd(4, v); chk(v == 32'h0004, "R9 scan data", v, 32'h0004);
    chk(pos % 64 == 0 && !frame_err && rises > r0 - 1, "R9 stop at frame end", pos % 64, 0);
    // read-only registers
    wr(5, 32'hFFFF_FFFF); wr(4, 32'h0);
    rd(5, v); chk(v == 32'd0, "R11 status ignores write", v, 0);
    rd(4, v); chk(v == 32'h0004, "R11 rx ignores write", v, 32'h0004);
    summary();
    $finish;
  end
endmodule